// File: doc/BRIEF.md
# Multiplexed-Bus Read Sequencer with Programmable Phase Timing

This block runs one read cycle at a time on an external bus. The bus carries the address and the data on the same pins. A caller presents an address, the byte lanes it wants and a 16-bit timing word. The sequencer then does the following, in order:

1. It asserts a memory select.
2. It pulses an address-latch enable while the address is driven onto the shared pins.
3. It releases the pins.
4. It drops a read strobe for a programmed length.
5. It samples the returned data as the strobe rises, and reports the data with a one-cycle done pulse.
6. It holds the select for one bus clock more and then returns to idle.

Several phase edges fall on half-bus-clock boundaries. For this reason the block runs on a clock at twice the bus rate, and it counts every phase in half-periods (one sequencer clock = half a bus clock). The timing word and the request are captured when the request is accepted, so the cycle in flight cannot be disturbed. A small behavioural model of the external address latch is included. It lets a system see when the demultiplexed address becomes valid.

Top module: `xbus_read_seq`

## Requirements
- R1: After reset, `ms_n`=1, `ale`=0, `rd_n`=1, `be_n` all ones, `ad_oe`=0, `done`=0 and `ready`=1.
- R2: A request is taken on a clock edge where `ready` and `req_valid` are both high. `ms_n` goes low in the following cycle, and `ale` rises exactly one half-period (one clock) later.
- R3: `ale` stays high for 2×(cfg[14:12]+1) clocks.
- R4: From the `ms_n` fall, `ad_oe` is high and `ad_out` carries the request address. This lasts until 1+2×(cfg[10]==0) clocks after `ale` falls. `ad_oe` is low otherwise.
- R5: `rd_n` falls 1+2×(cfg[10]==0)+2×(cfg[9]==0) clocks after `ale` falls. `ad_oe` is never high while `rd_n` is low.
- R6: `rd_n` stays low for 2×(cfg[3:0]+1) clocks.
- R7: `be_n` equals the bitwise inverse of `req_be` (bit i covers byte lane i) during the last two clocks of the `rd_n` low time. `be_n` is all ones at every other time.
- R8: `ad_in` is sampled on the edge where `rd_n` returns high. The sample appears on `rd_data`, with `done` high for exactly that one following cycle.
- R9: `ms_n` stays low for 2 clocks after `rd_n` rises and then goes high. `ready` rises in that same cycle, so no new address can be driven sooner.
- R10: `req_valid`, `req_addr`, `req_be` and `cfg` changes while `ready` is low have no effect on the cycle in flight, and they do not start another cycle.
- R11: `lat_addr` holds the address that was on `ad_out` while `ale` was high, and it keeps that value after the pins are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request |
| req_addr | input | BUS_W | Read address |
| req_be | input | BUS_W/8 | Byte lanes wanted, active high |
| cfg | input | 16 | Phase timing word |
| ready | output | 1 | Idle, request may be taken |
| done | output | 1 | One-cycle pulse, `rd_data` valid |
| rd_data | output | BUS_W | Captured read data |
| ms_n | output | 1 | Memory select, active low |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| be_n | output | BUS_W/8 | Byte enables, active low |
| ad_out | output | BUS_W | Address driven onto shared pins |
| ad_oe | output | 1 | Shared-pin output enable |
| ad_in | input | BUS_W | Data from shared pins |
| lat_addr | output | BUS_W | Modelled external latch output |

## Verification
Two events can meet in a single clock edge:

- **Address release and strobe fall.** With cfg[9] set, the address hold time equals the delay to the strobe fall, so the address is released on the same edge that drops the strobe. Runs with cfg[9] set and both values of cfg[10] produce this case. The bench judges it by counting clocks where `ad_oe` and a low `rd_n` overlap, which must be zero. It also checks that the first strobe clock directly follows the last address clock.
- **Cycle completion and next acceptance.** A new request is held waiting so that it is taken in the very cycle `ready` returns. The bench checks that the second select starts only after the first has been high again.

// File: rtl/xrs_pkg.sv
`timescale 1ns/1ps
package xrs_pkg;
  localparam int CFG_W = 16;
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SEL, PH_LATCH, PH_GAP, PH_STROBE, PH_TAIL
  } phase_t;

  typedef struct packed {
    logic [2:0] ale_f;
    logic       hold_short;   // set: no extra clock of address hold
    logic       gap_short;    // set: no extra clock before the strobe
    logic [3:0] rd_f;
  } timing_t;

  function automatic timing_t decode_cfg(input logic [CFG_W-1:0] r);
    timing_t t;
    t.ale_f      = r[14:12];
    t.hold_short = r[10];
    t.gap_short  = r[9];
    t.rd_f       = r[3:0];
    return t;
  endfunction

  function automatic logic [CNT_W-1:0] ale_halves(input timing_t t);
    logic [CNT_W-1:0] v;
    v = CNT_W'(t.ale_f) + CNT_W'(1);
    return v << 1;
  endfunction

  function automatic logic [CNT_W-1:0] hold_halves(input timing_t t);
    return t.hold_short ? CNT_W'(1) : CNT_W'(3);
  endfunction

  function automatic logic [CNT_W-1:0] gap_halves(input timing_t t);
    logic [CNT_W-1:0] v;
    v = CNT_W'(1);
    if (!t.hold_short) v = v + CNT_W'(2);
    if (!t.gap_short)  v = v + CNT_W'(2);
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] strobe_halves(input timing_t t);
    logic [CNT_W-1:0] v;
    v = CNT_W'(t.rd_f) + CNT_W'(1);
    return v << 1;
  endfunction
endpackage

// File: rtl/xrs_ctrl.sv
`timescale 1ns/1ps
module xrs_ctrl
  import xrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CFG_W-1:0] cfg,
  output logic             accept_o,
  output logic             sel_o,
  output logic             ale_o,
  output logic             addr_drv_o,
  output logic             strobe_o,
  output logic             be_win_o,
  output logic             capture_o,
  output logic             ready_o
);
  timing_t          tm_q;
  phase_t           ph_q, ph_nxt;
  logic [CNT_W-1:0] cnt_q, len;
  logic             last;

  always_comb begin
    case (ph_q)
      PH_LATCH:  len = ale_halves(tm_q);
      PH_GAP:    len = gap_halves(tm_q);
      PH_STROBE: len = strobe_halves(tm_q);
      PH_TAIL:   len = CNT_W'(2);
      default:   len = CNT_W'(1);
    endcase
  end

  assign last = (cnt_q == len - CNT_W'(1));

  always_comb begin
    case (ph_q)
      PH_SEL:    ph_nxt = PH_LATCH;
      PH_LATCH:  ph_nxt = PH_GAP;
      PH_GAP:    ph_nxt = PH_STROBE;
      PH_STROBE: ph_nxt = PH_TAIL;
      default:   ph_nxt = PH_IDLE;
    endcase
  end

  assign accept_o = (ph_q == PH_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tm_q  <= '0;
    end else if (accept_o) begin
      tm_q  <= decode_cfg(cfg);
      ph_q  <= PH_SEL;
      cnt_q <= '0;
    end else if (ph_q != PH_IDLE) begin
      if (last) begin
        ph_q  <= ph_nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign ready_o    = (ph_q == PH_IDLE);
  assign sel_o      = (ph_q != PH_IDLE);
  assign ale_o      = (ph_q == PH_LATCH);
  assign addr_drv_o = (ph_q == PH_SEL) || (ph_q == PH_LATCH) ||
                      ((ph_q == PH_GAP) && (cnt_q < hold_halves(tm_q)));
  assign strobe_o   = (ph_q == PH_STROBE);
  assign be_win_o   = (ph_q == PH_STROBE) && (cnt_q >= len - CNT_W'(2));
  assign capture_o  = (ph_q == PH_STROBE) && last;

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |=> (ph_q != PH_SEL)); // R10
  AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> (cnt_q < len)); // R6
  AST_CAPTURE_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> (ph_q == PH_TAIL)); // R8
endmodule

// File: rtl/xrs_capture.sv
`timescale 1ns/1ps
module xrs_capture #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] rd_data,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= capture;
      if (capture) rd_data <= ad_in;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

// File: rtl/xrs_addr_latch.sv
`timescale 1ns/1ps
module xrs_addr_latch #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic             ad_oe,
  input  logic [BUS_W-1:0] ad_out,
  output logic [BUS_W-1:0] lat_addr
);
  // Transparent-while-high latch, modelled at half-bus-clock resolution.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lat_addr <= '0;
    else if (ale && ad_oe)  lat_addr <= ad_out;
  end

  AST_LATCH_SEES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe); // R11
endmodule

// File: rtl/xbus_read_seq.sv
`timescale 1ns/1ps
module xbus_read_seq
  import xrs_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [BUS_W-1:0]   req_addr,
  input  logic [BUS_W/8-1:0] req_be,
  input  logic [CFG_W-1:0]   cfg,
  output logic               ready,
  output logic               done,
  output logic [BUS_W-1:0]   rd_data,
  output logic               ms_n,
  output logic               ale,
  output logic               rd_n,
  output logic [BUS_W/8-1:0] be_n,
  output logic [BUS_W-1:0]   ad_out,
  output logic               ad_oe,
  input  logic [BUS_W-1:0]   ad_in,
  output logic [BUS_W-1:0]   lat_addr
);
  localparam int BE_W = BUS_W / 8;

  logic            ev_accept, ev_sel, ev_ale, ev_addr_drv;
  logic            ev_strobe, ev_be_win, ev_capture;
  logic [BUS_W-1:0] addr_q;
  logic [BE_W-1:0]  be_q;

  xrs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg(cfg),
    .accept_o(ev_accept), .sel_o(ev_sel), .ale_o(ev_ale),
    .addr_drv_o(ev_addr_drv), .strobe_o(ev_strobe), .be_win_o(ev_be_win),
    .capture_o(ev_capture), .ready_o(ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
    end else if (ev_accept) begin
      addr_q <= req_addr;
      be_q   <= req_be;
    end
  end

  assign ms_n   = !ev_sel;
  assign ale    = ev_ale;
  assign rd_n   = !ev_strobe;
  assign ad_oe  = ev_addr_drv;
  assign ad_out = ev_addr_drv ? addr_q : '0;
  assign be_n   = ev_be_win ? ~be_q : {BE_W{1'b1}};

  xrs_capture #(.BUS_W(BUS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(ev_capture), .ad_in(ad_in),
    .rd_data(rd_data), .done(done)
  );

  xrs_addr_latch #(.BUS_W(BUS_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_oe(ad_oe), .ad_out(ad_out),
    .lat_addr(lat_addr)
  );

  AST_ALE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !ms_n); // R2
  AST_NO_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R5
  AST_BE_INSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (be_n != {BE_W{1'b1}}) |-> !rd_n); // R7
  AST_DONE_AT_RD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && $past(!rd_n))); // R8
  AST_MS_OUTLASTS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !ms_n); // R9
endmodule

// File: tb/xbus_read_seq_tb.sv
`timescale 1ns/1ps
module xbus_read_seq_tb;
  localparam int BUS_W = 16;
  localparam int BE_W  = BUS_W / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [BUS_W-1:0] req_addr = '0;
  logic [BE_W-1:0]  req_be = '0;
  logic [15:0]      cfg = '0;
  logic ready, done, ms_n, ale, rd_n, ad_oe;
  logic [BUS_W-1:0] rd_data, ad_out, ad_in, lat_addr, mem_word;
  logic [BE_W-1:0]  be_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign ad_in = (!rd_n) ? mem_word : 16'h0000;

  xbus_read_seq #(.BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_be(req_be), .cfg(cfg), .ready(ready), .done(done), .rd_data(rd_data),
    .ms_n(ms_n), .ale(ale), .rd_n(rd_n), .be_n(be_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .lat_addr(lat_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // One read cycle; starts at a negedge with the sequencer idle.
  task automatic run_read(input logic [15:0] c, input logic [15:0] a,
                          input logic [1:0] be, input logic [15:0] d,
                          input bit disturb, input bit chain);
    int L, H, D, S;
    int first_ms = 0, first_ale = 0, ale_cnt = 0, last_oe = 0, bad_addr = 0;
    int first_rd = 0, rd_cnt = 0, first_be = 0, be_cnt = 0, be_bad = 0;
    int done_idx = 0, done_cnt = 0, data_at = 0, last_ms = 0, rdy_idx = 0, overlap = 0;
    L = 2 * (((c >> 12) & 7) + 1);
    H = c[10] ? 1 : 3;
    D = 1 + (c[10] ? 0 : 2) + (c[9] ? 0 : 2);
    S = 2 * ((c & 15) + 1);
    mem_word = d;
    cfg = c; req_addr = a; req_be = be; req_valid = 1'b1;
    @(posedge clk);
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (disturb && k == 3) begin
        cfg = 16'h0000; req_addr = ~a; req_be = ~be; req_valid = 1'b1;
      end
      if (disturb && k == 4) req_valid = 1'b0;
      if (!ms_n) begin if (first_ms == 0) first_ms = k; last_ms = k; end
      if (ale) begin if (first_ale == 0) first_ale = k; ale_cnt++; end
      if (ad_oe) begin last_oe = k; if (ad_out != a) bad_addr++; end
      if (!rd_n) begin if (first_rd == 0) first_rd = k; rd_cnt++; if (ad_oe) overlap++; end
      if (be_n != 2'b11) begin
        if (first_be == 0) first_be = k;
        be_cnt++;
        if (be_n != ~be) be_bad++;
      end
      if (done) begin done_cnt++; done_idx = k; data_at = rd_data; end
      if (ready) begin rdy_idx = k; break; end
    end
    chk("R2 select falls after accept", first_ms, 1);
    chk("R2 ale rises half bus clock after select", first_ale, 2);
    chk("R3 ale width", ale_cnt, L);
    chk("R4 last address drive clock", last_oe, 1 + L + H);
    chk("R4 address value on pins", bad_addr, 0);
    chk("R5 strobe fall position", first_rd, 2 + L + D);
    chk("R5 drive overlaps strobe", overlap, 0);
    chk("R6 strobe width", rd_cnt, S);
    chk("R7 byte enable start", first_be, L + D + S);
    chk("R7 byte enable length", be_cnt, 2);
    chk("R7 byte enable value", be_bad, 0);
    chk("R8 done position", done_idx, 2 + L + D + S);
    chk("R8 done width", done_cnt, 1);
    chk("R8 captured data", data_at, int'(d));
    chk("R9 select release", last_ms, 3 + L + D + S);
    chk("R9 ready return", rdy_idx, 4 + L + D + S);
    chk("R11 latched address", int'(lat_addr), int'(a));
    if (!chain) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R10 no extra cycle started", int'(ms_n), 1);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 ms_n", int'(ms_n), 1);
    chk("R1 ale", int'(ale), 0);
    chk("R1 rd_n", int'(rd_n), 1);
    chk("R1 be_n", int'(be_n), 3);
    chk("R1 ad_oe", int'(ad_oe), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ready", int'(ready), 1);
  endtask

  task automatic t_minimal();   run_read(16'h0600, 16'h1234, 2'b11, 16'hA5A5, 0, 0); endtask
  task automatic t_longest();   run_read(16'h700F, 16'hBEEF, 2'b01, 16'h5A5A, 0, 0); endtask
  task automatic t_hold_long(); run_read(16'h2203, 16'h0F0F, 2'b10, 16'hC3C3, 0, 0); endtask
  task automatic t_gap_long();  run_read(16'h3402, 16'h8001, 2'b11, 16'h7E7E, 0, 0); endtask
  task automatic t_disturb();   run_read(16'h5605, 16'h4242, 2'b01, 16'h1111, 1, 0); endtask
  task automatic t_chain();
    run_read(16'h1601, 16'h2468, 2'b11, 16'h3333, 0, 1);
    run_read(16'h0000, 16'h1357, 2'b10, 16'h9999, 0, 0);
  endtask

  initial begin
    mem_word = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_minimal();
    t_longest();
    t_hold_long();
    t_gap_long();
    t_disturb();
    t_chain();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule